// File: doc/BRIEF.md
# Serial Interface Mode Arbiter

This block chooses between the two operating personalities of a telephony codec's shared system port. One personality is a PCM data path with a serial control port. The other is a time-multiplexed digital-loop (GCI) link. The block reads two shared pins: a chip-select pin that also acts as a mode strap, and a data-clock pin that also acts as a select line. It also takes a strobe from the control decoder that marks each accepted command, and a frame tick that marks each PCM frame. From these it works out the current mode.

A quiet port selects the loop link. A quiet port means chip-select is held low and the data clock shows no edges for a full frame. Any activity on the port selects the PCM/control mode. After the first command is accepted in PCM mode, the loop link cannot be chosen again. If chip-select is held low across a counted number of data-clock rising edges, the block requests a hardware reset on the moment chip-select returns high. That request clears the lock and starts the evaluation again from the beginning. Both pins pass through two-flop synchronizers before any decision uses them.

Top module: `ifaceModeArb`

## Requirements
- R1: Immediately after `rstN` is released, `mode` is 0 (undecided), `resetReq` is 0 and `gciLocked` is 0. Mode codes: 0 undecided, 1 PCM/control, 2 loop link.
- R2: If `csPg` is low, `dclkS0` is static and no lock is held, `mode` becomes 2 on the clock after the QUIET_TICKS-th `frameTick` (default 2) of one uninterrupted quiet period. This applies from mode 0 and from mode 1. Before that clock, `mode` is not 2.
- R3: From mode 0, a high `csPg` or any `dclkS0` edge sets `mode` to 1.
- R4: A `cmdValid` pulse while `mode` is 1 sets `gciLocked`. While `gciLocked` is set, quiet periods never produce mode 2. A `cmdValid` pulse while `mode` is 2 leaves `gciLocked` at 0.
- R5: In mode 2, a pin change (`csPg` rising or a `dclkS0` edge) shows as `mode` 1 on the third rising clock edge after the pin changes, and not earlier.
- R6: Any `dclkS0` edge, or `csPg` high, restarts the count of quiet frame ticks.
- R7: If `dclkS0` rises HOLD_EDGES times (default 16) during one low period of `csPg`, `resetReq` is high for exactly one cycle. It rises on the third clock edge after `csPg` goes high.
- R8: Fewer than HOLD_EDGES rising edges in a low period produce no `resetReq`. Each high period clears the count, so edges from separate low periods do not add up.
- R9: A reset request clears `gciLocked` and returns the block to evaluation, so mode 2 can be reached again.
- R10: During the first clocks after reset, the `dclkS0` level is not treated as an edge. A power-up with `dclkS0` static high and `csPg` low still reaches mode 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Power-on reset, asynchronous, active low |
| csPg | input | 1 | Shared chip-select / mode strap pin (asynchronous) |
| dclkS0 | input | 1 | Shared data-clock / select pin (asynchronous) |
| cmdValid | input | 1 | One-cycle strobe: control decoder accepted a command |
| frameTick | input | 1 | One-cycle strobe once per PCM frame |
| mode | output | 2 | 0 undecided, 1 PCM/control, 2 loop link |
| resetReq | output | 1 | One-cycle hardware reset request |
| gciLocked | output | 1 | Loop link permanently refused until reset |

## Verification
The bench sweeps the edge count of a long chip-select hold from 14 to 17. A counter that is off by one would fire at 15 edges or stay silent at 16. A design that never clears the counter would fire on two short holds added together. The bench counts frame ticks one at a time, so entering the loop link one frame early or one frame late is caught. It also inserts a clock edge between the ticks, which catches a design that keeps counting across activity. Each exit from the loop link is timed to the exact cycle. The bench powers up with the data clock already high, which exposes a design that treats an unprimed synchronizer as an edge. It also checks the lock with a command accepted in PCM mode against one that arrives during the loop link.

// File: rtl/ifaceModePkg.sv
package ifaceModePkg;

  typedef enum logic [1:0] {
    MODE_EVAL = 2'd0,
    MODE_PCM  = 2'd1,
    MODE_GCI  = 2'd2
  } arbMode_t;

  typedef struct packed {
    logic pinActive;
    logic quietDone;
    logic longRelease;
  } arbStrobe_t;

endpackage

// File: rtl/ifaceSync2.sv
module ifaceSync2 #(
  parameter int WIDTH = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [WIDTH-1:0] stageA;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stageA  <= '0;
      syncOut <= '0;
    end else begin
      stageA  <= asyncIn;
      syncOut <= stageA;
    end
  end

endmodule

// File: rtl/ifaceModeDatapath.sv
module ifaceModeDatapath
  import ifaceModePkg::*;
#(
  parameter int HOLD_EDGES  = 16,
  parameter int QUIET_TICKS = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       csPg,
  input  logic       dclkS0,
  input  logic       frameTick,
  output arbStrobe_t strobe
);

  localparam int HOLD_W  = $clog2(HOLD_EDGES + 1);
  localparam int QUIET_W = $clog2(QUIET_TICKS + 1);
  localparam int SYNC_STAGES = 2;
  localparam int WARM_W  = $clog2(SYNC_STAGES + 2);
  localparam logic [WARM_W-1:0] WARM_DONE = WARM_W'(SYNC_STAGES + 1);

  logic [1:0] pinSync;
  logic csS, dclkS, csPrev, dclkPrev;
  logic [WARM_W-1:0]  warmCnt;
  logic [HOLD_W-1:0]  holdCnt;
  logic [QUIET_W-1:0] quietCnt;
  logic warm, dclkEdge, dclkRise, csRise, pinActive;

  ifaceSync2 #(.WIDTH(2)) uSync (
    .clk    (clk),
    .rstN   (rstN),
    .asyncIn({dclkS0, csPg}),
    .syncOut(pinSync)
  );

  assign csS   = pinSync[0];
  assign dclkS = pinSync[1];

  assign warm      = (warmCnt == WARM_DONE);
  assign dclkEdge  = warm & (dclkS ^ dclkPrev);
  assign dclkRise  = warm & dclkS & ~dclkPrev;
  assign csRise    = warm & csS & ~csPrev;
  assign pinActive = csS | dclkEdge;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      warmCnt  <= '0;
      csPrev   <= 1'b0;
      dclkPrev <= 1'b0;
    end else begin
      if (!warm) warmCnt <= warmCnt + 1'b1;
      csPrev   <= csS;
      dclkPrev <= dclkS;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdCnt <= '0;
    end else if (csS) begin
      holdCnt <= '0;
    end else if (dclkRise && holdCnt != HOLD_W'(HOLD_EDGES)) begin
      holdCnt <= holdCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      quietCnt <= '0;
    end else if (pinActive) begin
      quietCnt <= '0;
    end else if (warm && frameTick && quietCnt != QUIET_W'(QUIET_TICKS)) begin
      quietCnt <= quietCnt + 1'b1;
    end
  end

  assign strobe.pinActive   = pinActive;
  assign strobe.quietDone   = (quietCnt == QUIET_W'(QUIET_TICKS));
  assign strobe.longRelease = csRise && (holdCnt == HOLD_W'(HOLD_EDGES));

  AST_HOLD_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    csS |=> (holdCnt == '0)); // R8
  AST_QUIET_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    pinActive |=> (quietCnt == '0)); // R6

endmodule

// File: rtl/ifaceModeCtrl.sv
module ifaceModeCtrl
  import ifaceModePkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  arbStrobe_t strobe,
  input  logic       cmdValid,
  output arbMode_t   modeState,
  output logic       resetReqReg,
  output logic       lockReg
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeState   <= MODE_EVAL;
      lockReg     <= 1'b0;
      resetReqReg <= 1'b0;
    end else begin
      resetReqReg <= strobe.longRelease;
      if (strobe.longRelease) begin
        modeState <= MODE_EVAL;
        lockReg   <= 1'b0;
      end else begin
        unique case (modeState)
          MODE_EVAL: begin
            if (strobe.pinActive)      modeState <= MODE_PCM;
            else if (strobe.quietDone) modeState <= MODE_GCI;
          end
          MODE_PCM: begin
            if (!lockReg && !cmdValid && strobe.quietDone && !strobe.pinActive)
              modeState <= MODE_GCI;
          end
          MODE_GCI: begin
            if (strobe.pinActive) modeState <= MODE_PCM;
          end
          default: modeState <= MODE_EVAL;
        endcase
        if (modeState == MODE_PCM && cmdValid) lockReg <= 1'b1;
      end
    end
  end

  AST_LOCK_NO_GCI: assert property (@(posedge clk) disable iff (!rstN)
    lockReg |-> (modeState != MODE_GCI)); // R4
  AST_GCI_EXIT: assert property (@(posedge clk) disable iff (!rstN)
    (modeState == MODE_GCI && strobe.pinActive && !strobe.longRelease)
      |=> (modeState == MODE_PCM)); // R5
  AST_RESET_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    resetReqReg |=> !resetReqReg); // R7
  AST_RESET_UNLOCK: assert property (@(posedge clk) disable iff (!rstN)
    resetReqReg |-> (!lockReg && modeState == MODE_EVAL)); // R9

endmodule

// File: rtl/ifaceModeArb.sv
module ifaceModeArb
  import ifaceModePkg::*;
#(
  parameter int HOLD_EDGES  = 16,
  parameter int QUIET_TICKS = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       csPg,
  input  logic       dclkS0,
  input  logic       cmdValid,
  input  logic       frameTick,
  output logic [1:0] mode,
  output logic       resetReq,
  output logic       gciLocked
);

  arbStrobe_t strobe;
  arbMode_t   modeState;

  ifaceModeDatapath #(
    .HOLD_EDGES (HOLD_EDGES),
    .QUIET_TICKS(QUIET_TICKS)
  ) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .csPg     (csPg),
    .dclkS0   (dclkS0),
    .frameTick(frameTick),
    .strobe   (strobe)
  );

  ifaceModeCtrl uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .cmdValid   (cmdValid),
    .modeState  (modeState),
    .resetReqReg(resetReq),
    .lockReg    (gciLocked)
  );

  assign mode = modeState;

endmodule

// File: tb/sim_ifaceModeArb.sv
`timescale 1ns/1ps
module sim_ifaceModeArb;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csPg = 1'b0, dclkS0 = 1'b0, cmdValid = 1'b0, frameTick = 1'b0;
  logic [1:0] mode;
  logic resetReq, gciLocked;
  int runCnt = 0, failCnt = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ifaceModeArb u0 (
    .clk(clk), .rstN(rstN), .csPg(csPg), .dclkS0(dclkS0),
    .cmdValid(cmdValid), .frameTick(frameTick),
    .mode(mode), .resetReq(resetReq), .gciLocked(gciLocked)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    runCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic doReset(input logic csV, input logic dclkV);
    @(negedge clk);
    csPg = csV; dclkS0 = dclkV; rstN = 1'b0;
    step(2);
    rstN = 1'b1;
  endtask

  task automatic tick();
    frameTick = 1'b1;
    step(1);
    frameTick = 1'b0;
  endtask

  task automatic dclkPulse();
    dclkS0 = 1'b1; step(3);
    dclkS0 = 1'b0; step(3);
  endtask

  task automatic reachGci(input string tag);
    step(4);
    tick(); step(1);
    tick();
    check(mode != 2'd2, {tag, " early"}, mode, 0);
    step(1);
    check(mode == 2'd2, tag, mode, 2);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      failCnt++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  [TB] %0d tests run, %0d failed", runCnt, failCnt);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    doReset(1'b0, 1'b0);
    check(mode == 2'd0, "R1 mode", mode, 0);
    check(!gciLocked, "R1 lock", gciLocked, 0);
    check(!resetReq, "R1 req", resetReq, 0);
    // R2 quiet entry counted in ticks
    step(4);
    tick(); step(1);
    check(mode == 2'd0, "R2 one tick", mode, 0);
    tick();
    check(mode == 2'd0, "R2 last tick", mode, 0);
    step(1);
    check(mode == 2'd2, "R2 enter", mode, 2);
    // R5 exit on chip-select high, exact cycle
    csPg = 1'b1; step(2);
    check(mode == 2'd2, "R5 cs not early", mode, 2);
    step(1);
    check(mode == 2'd1, "R5 cs exit", mode, 1);
    // R5 exit on data-clock edge
    doReset(1'b0, 1'b0);
    reachGci("R2 again");
    dclkS0 = 1'b1; step(2);
    check(mode == 2'd2, "R5 dclk not early", mode, 2);
    step(1);
    check(mode == 2'd1, "R5 dclk exit", mode, 1);
    // R3 from undecided via edge and via chip-select
    doReset(1'b0, 1'b0);
    step(4);
    dclkPulse();
    check(mode == 2'd1, "R3 edge", mode, 1);
    doReset(1'b1, 1'b0);
    step(4);
    check(mode == 2'd1, "R3 cs", mode, 1);
    // R6 activity restarts quiet count
    doReset(1'b0, 1'b0);
    step(4);
    tick(); step(1);
    dclkPulse();
    tick(); step(1);
    check(mode == 2'd1, "R6 restart", mode, 1);
    tick(); step(1);
    check(mode == 2'd2, "R6 reenter", mode, 2);
    // R4 command in loop mode ignored, command in PCM locks
    cmdValid = 1'b1; step(1); cmdValid = 1'b0; step(1);
    check(!gciLocked, "R4 gci cmd", gciLocked, 0);
    csPg = 1'b1; step(4);
    cmdValid = 1'b1; step(1); cmdValid = 1'b0; step(1);
    check(gciLocked, "R4 lock", gciLocked, 1);
    csPg = 1'b0; step(4);
    for (int k = 0; k < 4; k++) begin tick(); step(1); end
    check(mode == 2'd1, "R4 stay pcm", mode, 1);
    // R7 R8 R9 sweep of hold edge counts
    for (int n = 14; n <= 17; n++) begin
      bit fire;
      fire = (n >= 16);
      doReset(1'b1, 1'b0);
      step(4);
      cmdValid = 1'b1; step(1); cmdValid = 1'b0; step(1);
      csPg = 1'b0; step(3);
      for (int p = 0; p < n; p++) dclkPulse();
      csPg = 1'b1; step(2);
      check(!resetReq, "R7 not early", resetReq, 0);
      step(1);
      check(resetReq == fire, fire ? "R7 pulse" : "R8 no pulse", resetReq, fire);
      check(gciLocked == !fire, "R9 lock cleared", gciLocked, !fire);
      step(1);
      check(!resetReq, "R7 one cycle", resetReq, 0);
      if (fire) begin
        csPg = 1'b0;
        reachGci("R9 gci after reset");
      end
    end
    // R8 two short holds do not add up
    doReset(1'b1, 1'b0);
    step(4);
    csPg = 1'b0; step(3);
    for (int p = 0; p < 10; p++) dclkPulse();
    csPg = 1'b1; step(4);
    csPg = 1'b0; step(3);
    for (int p = 0; p < 10; p++) dclkPulse();
    csPg = 1'b1;
    for (int c = 0; c < 6; c++) begin
      step(1);
      check(!resetReq, "R8 split holds", resetReq, 0);
    end
    // R10 power-up with data clock high and static
    doReset(1'b0, 1'b1);
    step(3);
    check(mode == 2'd0, "R10 no false edge", mode, 0);
    reachGci("R10 gci");
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", runCnt, failCnt);
    $finish;
  end

endmodule